// File: doc/BRIEF.md
# Preamble-validated serial byte receiver

This block receives bytes from one asynchronous serial line. Every byte on the line begins with a two-bit preamble. The first part is a long high level and the second is one standard-width low bit. The eight data bits follow with the least significant bit first. The receiver brings the line into its clock domain and measures how long the first high level lasts. It accepts that level only when its length lies inside a window. It restarts its bit timing at the falling edge that ends the level, and it confirms the low pad bit at its mid-point. It then samples each data bit at the middle of its period. A good byte produces a one-cycle valid pulse together with the data. A rejected preamble produces a one-cycle error pulse with a code that gives the cause.

The state machine has four states. HUNT waits for a high level. MEAS counts the high time. BITS times the pad bit and the data bits. STUCK waits out a high level that ran too long. The transitions are:
- hunt_to_meas: the line is high in HUNT.
- meas_to_bits: a falling edge arrives after an accepted length.
- meas_short: a falling edge arrives too early, and the machine goes back to HUNT.
- meas_long: the high level overruns the window, and the machine goes to STUCK.
- bits_sync_fail: the pad bit reads high, and the machine goes back to HUNT.
- bits_done: the last data bit period ends, and the machine goes back to HUNT.
- stuck_release: the line returns low, and the machine goes back to HUNT.

Each byte needs its own preamble, because the machine returns to HUNT after every byte. A separate timer raises a line-idle level when no byte has been in progress for a set number of cycles. All timing parameters are counted in clock cycles.

Top module: `pjr_rx`

## Requirements
- R1: While reset is held and on the first cycle after it, byte_valid, err_pulse and line_idle are 0, and err_kind is 2'b00.
- R2: A high level shorter than ACCEPT cycles produces exactly one err_pulse with err_kind 2'b01 (short) and no byte.
- R3: A high level longer than PAD_W+TOL cycles produces an err_pulse with err_kind 2'b10 (long) and no byte. No new byte starts until the line has gone low.
- R4: A high level of any length from ACCEPT to PAD_W+TOL inclusive is accepted, provided a low pad bit and eight data bits of BIT_W cycles each follow it.
- R5: If the line reads high at the middle of the pad bit (BIT_W/2 cycles after the falling edge), err_pulse fires with err_kind 2'b11 (sync) and the byte is dropped.
- R6: Data bits are assembled least significant bit first. For every one of the 256 byte values, byte_data matches the transmitted value during a byte_valid pulse that lasts one cycle. byte_valid and err_pulse are never high together.
- R7: After each byte the receiver hunts again. Back-to-back framed bytes are all received, and data-rate bits sent without a preamble yield no byte.
- R8: The line passes through a two-flop synchronizer. byte_valid is visible BIT_W/2 + 8*BIT_W + 3 rising edges after the line is driven low at the end of the long pad level.
- R9: line_idle rises once IDLE_TO cycles pass without a byte in progress. It drops once a preamble has been accepted, and it is never high together with byte_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Raw serial line, asynchronous to clk |
| byte_valid | output | 1 | One-cycle pulse: byte_data holds a received byte |
| byte_data | output | DW | Received byte, least significant bit first on the line |
| err_pulse | output | 1 | One-cycle pulse on a rejected preamble |
| err_kind | output | 2 | 01 short, 10 long, 11 sync; 00 when no error |
| line_idle | output | 1 | High after IDLE_TO cycles without a byte in progress |

## Verification
If the bit phase counter were wrong, the cycle distance from the falling edge to byte_valid would be off. Bits would also be sampled in the wrong period, so the data of the 256-value sweep would be shifted or would repeat bits within one byte time. A bad high-time count or bad window limit shows up in the length sweep at the ACCEPT-1/ACCEPT and PAD_W+TOL/PAD_W+TOL+1 boundaries, as a wrong error code or a missing or extra byte within two bit times of the pulse. If the machine failed to rearm after a byte, the next back-to-back byte would be lost at once.

// File: rtl/pjr_pkg.sv
package pjr_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_MEAS  = 2'd1,
        ST_BITS  = 2'd2,
        ST_STUCK = 2'd3
    } rx_state_e;

    localparam logic [1:0] ERR_NONE  = 2'b00;
    localparam logic [1:0] ERR_SHORT = 2'b01;
    localparam logic [1:0] ERR_LONG  = 2'b10;
    localparam logic [1:0] ERR_SYNC  = 2'b11;
endpackage

// File: rtl/pjr_sync2.sv
module pjr_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[i] <= 1'b0;
                end else if (i == 0) begin
                    chain[i] <= d;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pjr_idle_timer.sv
module pjr_idle_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic idle
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (cnt != CW'(LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign idle = (cnt == CW'(LIMIT));
endmodule

// File: rtl/pjr_rx.sv
module pjr_rx #(
    parameter int BIT_W   = 8,
    parameter int PAD_W   = 24,
    parameter int ACCEPT  = 16,
    parameter int TOL     = 4,
    parameter int IDLE_TO = 400,
    parameter int DW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_in,
    output logic          byte_valid,
    output logic [DW-1:0] byte_data,
    output logic          err_pulse,
    output logic [1:0]    err_kind,
    output logic          line_idle
);
    import pjr_pkg::*;

    localparam int HMAX = PAD_W + TOL;
    localparam int HALF = BIT_W / 2;
    localparam int HCW  = $clog2(HMAX + 1);
    localparam int PCW  = $clog2(BIT_W);
    localparam int BCW  = $clog2(DW + 1);

    logic            s_line;
    rx_state_e       state_q, state_d;
    logic [HCW-1:0]  hcnt_q, hcnt_d;
    logic [PCW-1:0]  pcnt_q, pcnt_d;
    logic [BCW-1:0]  bitn_q, bitn_d;
    logic [DW-1:0]   shf_q, shf_d;
    logic            ev_byte, ev_err;
    logic [1:0]      ev_kind;

    pjr_sync2 #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (s_line)
    );

    pjr_idle_timer #(.LIMIT(IDLE_TO)) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q == ST_BITS),
        .idle  (line_idle)
    );

    // next-state and event logic
    always_comb begin
        state_d = state_q;
        hcnt_d  = hcnt_q;
        pcnt_d  = pcnt_q;
        bitn_d  = bitn_q;
        shf_d   = shf_q;
        ev_byte = 1'b0;
        ev_err  = 1'b0;
        ev_kind = ERR_NONE;
        unique case (state_q)
            ST_HUNT: begin
                if (s_line) begin
                    state_d = ST_MEAS;
                    hcnt_d  = HCW'(1);
                end
            end
            ST_MEAS: begin
                if (s_line) begin
                    if (hcnt_q == HCW'(HMAX)) begin
                        ev_err  = 1'b1;
                        ev_kind = ERR_LONG;
                        state_d = ST_STUCK;
                    end else begin
                        hcnt_d = hcnt_q + 1'b1;
                    end
                end else if (hcnt_q >= HCW'(ACCEPT)) begin
                    // falling edge cycle is phase 0 of the low pad bit
                    state_d = ST_BITS;
                    pcnt_d  = PCW'(1);
                    bitn_d  = '0;
                end else begin
                    ev_err  = 1'b1;
                    ev_kind = ERR_SHORT;
                    state_d = ST_HUNT;
                end
            end
            ST_BITS: begin
                if (pcnt_q == PCW'(BIT_W - 1)) begin
                    pcnt_d = '0;
                    bitn_d = bitn_q + 1'b1;
                    if (bitn_q == BCW'(DW)) begin
                        state_d = ST_HUNT;
                    end
                end else begin
                    pcnt_d = pcnt_q + 1'b1;
                end
                if (pcnt_q == PCW'(HALF)) begin
                    if (bitn_q == '0) begin
                        if (s_line) begin
                            ev_err  = 1'b1;
                            ev_kind = ERR_SYNC;
                            state_d = ST_HUNT;
                        end
                    end else begin
                        shf_d = {s_line, shf_q[DW-1:1]};
                        if (bitn_q == BCW'(DW)) begin
                            ev_byte = 1'b1;
                        end
                    end
                end
            end
            ST_STUCK: begin
                if (!s_line) begin
                    state_d = ST_HUNT;
                end
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            hcnt_q  <= '0;
            pcnt_q  <= '0;
            bitn_q  <= '0;
            shf_q   <= '0;
        end else begin
            state_q <= state_d;
            hcnt_q  <= hcnt_d;
            pcnt_q  <= pcnt_d;
            bitn_q  <= bitn_d;
            shf_q   <= shf_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_valid <= 1'b0;
            byte_data  <= '0;
            err_pulse  <= 1'b0;
            err_kind   <= ERR_NONE;
        end else begin
            byte_valid <= ev_byte;
            if (ev_byte) begin
                byte_data <= shf_d;
            end
            err_pulse <= ev_err;
            err_kind  <= ev_err ? ev_kind : ERR_NONE;
        end
    end
endmodule

// File: rtl/pjr_rx_chk.sv
module pjr_rx_chk #(
    parameter int HMAX = 28,
    parameter int HCW  = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           byte_valid,
    input logic           err_pulse,
    input logic [1:0]     err_kind,
    input logic           line_idle,
    input logic           in_meas,
    input logic [HCW-1:0] hcnt
);
    // R6: data and error events never coincide
    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && err_pulse));

    // R6: valid is a single-cycle pulse
    p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R2: an error always carries a non-zero cause
    p_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (err_kind != 2'b00));

    // R2: no cause code without an error pulse
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !err_pulse |-> (err_kind == 2'b00));

    // R3: high-time measurement never passes its upper limit
    p_hbound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_meas |-> (hcnt <= HCW'(HMAX)));

    // R3: a long rejection is not followed at once by a byte
    p_nobyte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && err_kind == 2'b10) |=> !byte_valid);

    // R9: idle never shows while a byte is delivered
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> !line_idle);
endmodule

bind pjr_rx pjr_rx_chk #(.HMAX(HMAX), .HCW(HCW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .err_pulse  (err_pulse),
    .err_kind   (err_kind),
    .line_idle  (line_idle),
    .in_meas    (state_q == pjr_pkg::ST_MEAS),
    .hcnt       (hcnt_q)
);

// File: tb/tb_pjr_rx.sv
`timescale 1ns/1ps
module tb_pjr_rx;
    localparam int BIT_W   = 8;
    localparam int PAD_W   = 24;
    localparam int ACCEPT  = 16;
    localparam int TOL     = 4;
    localparam int IDLE_TO = 400;
    localparam int HMAX    = PAD_W + TOL;
    localparam int LAT     = BIT_W/2 + 8*BIT_W + 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b0;
    logic       byte_valid, err_pulse, line_idle;
    logic [7:0] byte_data;
    logic [1:0] err_kind;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int rx_n = 0;
    int errc [4];
    logic [7:0] rx_q [1024];
    int rx_cyc [1024];
    int fall_cyc [1024];
    int tx_n = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pjr_rx #(.BIT_W(BIT_W), .PAD_W(PAD_W), .ACCEPT(ACCEPT), .TOL(TOL),
             .IDLE_TO(IDLE_TO), .DW(8)) dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .err_pulse(err_pulse), .err_kind(err_kind), .line_idle(line_idle));

    initial for (int i = 0; i < 4; i++) errc[i] = 0;

    // output monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n && byte_valid) begin
            rx_q[rx_n % 1024]   <= byte_data;
            rx_cyc[rx_n % 1024] <= cyc;
            rx_n <= rx_n + 1;
        end
        if (rst_n && err_pulse) errc[err_kind] <= errc[err_kind] + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic lvl(input logic v, input int n);
        line_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input int hlen);
        lvl(1'b1, hlen);
        fall_cyc[tx_n % 1024] = cyc;
        tx_n++;
        lvl(1'b0, BIT_W);
        for (int k = 0; k < 8; k++) lvl(b[k], BIT_W);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int base_rx, base_e;
        @(negedge clk);
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(byte_valid == 0 && err_pulse == 0, "R1 pulses in reset", int'(byte_valid | err_pulse), 0);
        chk(line_idle == 0 && err_kind == 0, "R1 idle/kind in reset", int'({line_idle, err_kind}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(byte_valid == 0 && err_pulse == 0 && line_idle == 0, "R1 after reset",
            int'({byte_valid, err_pulse, line_idle}), 0);

        // R6/R7/R8: all 256 values back to back, nominal pad
        lvl(1'b0, 2*BIT_W);
        base_rx = rx_n;
        for (int v = 0; v < 256; v++) send_byte(v[7:0], PAD_W);
        lvl(1'b0, 3*BIT_W);
        chk(rx_n - base_rx == 256, "R7 stream count", rx_n - base_rx, 256);
        for (int v = 0; v < 256; v++) begin
            chk(rx_q[(base_rx + v) % 1024] == v[7:0], "R6 lsb-first data",
                int'(rx_q[(base_rx + v) % 1024]), v);
            chk(rx_cyc[(base_rx + v) % 1024] - fall_cyc[v] == LAT, "R8 latency",
                rx_cyc[(base_rx + v) % 1024] - fall_cyc[v], LAT);
        end
        chk(errc[1] + errc[2] + errc[3] == 0, "R7 no errors in stream",
            errc[1] + errc[2] + errc[3], 0);

        // R2: every too-short length
        for (int L = 1; L < ACCEPT; L++) begin
            base_rx = rx_n; base_e = errc[1];
            lvl(1'b1, L);
            lvl(1'b0, 3*BIT_W);
            chk(errc[1] - base_e == 1, "R2 short error", errc[1] - base_e, 1);
            chk(rx_n == base_rx, "R2 no byte", rx_n - base_rx, 0);
        end

        // R4: every accepted length
        for (int L = ACCEPT; L <= HMAX; L++) begin
            base_rx = rx_n;
            send_byte(8'(L) ^ 8'hA5, L);
            lvl(1'b0, 2*BIT_W);
            chk(rx_n - base_rx == 1, "R4 window accept", rx_n - base_rx, 1);
            chk(rx_q[(rx_n + 1023) % 1024] == (8'(L) ^ 8'hA5), "R4 window data",
                int'(rx_q[(rx_n + 1023) % 1024]), int'(8'(L) ^ 8'hA5));
        end

        // R3: too long, held high a while
        for (int L = HMAX + 1; L <= HMAX + 41; L += 20) begin
            base_rx = rx_n; base_e = errc[2];
            lvl(1'b1, L);
            lvl(1'b0, BIT_W);
            for (int k = 0; k < 8; k++) lvl(k[0], BIT_W);
            lvl(1'b0, 2*BIT_W);
            chk(errc[2] - base_e == 1, "R3 long error", errc[2] - base_e, 1);
            chk(rx_n == base_rx, "R3 no byte", rx_n - base_rx, 0);
        end

        // R5: pad bit reads high
        base_rx = rx_n; base_e = errc[3];
        lvl(1'b1, PAD_W);
        lvl(1'b0, 2);
        lvl(1'b1, BIT_W);
        lvl(1'b0, 4*BIT_W);
        chk(errc[3] - base_e == 1, "R5 sync error", errc[3] - base_e, 1);
        chk(rx_n == base_rx, "R5 byte dropped", rx_n - base_rx, 0);

        // R7: data-rate bits without a preamble after a byte
        base_rx = rx_n;
        send_byte(8'h3C, PAD_W);
        for (int k = 0; k < 8; k++) lvl(k[0], BIT_W);
        lvl(1'b0, 2*BIT_W);
        chk(rx_n - base_rx == 1, "R7 only framed byte", rx_n - base_rx, 1);

        // R9: idle timing
        chk(line_idle == 0, "R9 not idle yet", int'(line_idle), 0);
        lvl(1'b0, IDLE_TO + 10);
        chk(line_idle == 1, "R9 idle after timeout", int'(line_idle), 1);
        lvl(1'b1, PAD_W);
        lvl(1'b0, BIT_W);
        chk(line_idle == 0, "R9 idle cleared", int'(line_idle), 0);
        for (int k = 0; k < 8; k++) lvl(1'b0, BIT_W);
        lvl(1'b0, 2*BIT_W);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule